// File: doc/BRIEF.md
# Iterative Multiply-Step Unit

This block multiplies by repeated shift-and-add steps. It holds three pieces of state: a partial-product accumulator, a Y register that carries the multiplier in and the low product out, and a four-bit flag set (negative, zero, overflow, carry). Each step shifts the accumulator right. The bit that enters its top is the exclusive-OR of the negative and overflow flags from the previous step, which acts as the true sign of the previous 33-bit sum. The step then adds the multiplicand when the bit leaving the bottom of Y was set.

There are two ways to drive it. A single-step command performs one step on operands supplied at the ports and registers the result. A start command clears the accumulator and the flags, loads Y with the multiplier, and runs the whole sequence on internal state: 32 conditional-add steps, then one alignment step that adds zero. At the end, the high half of the product sits in the accumulator and the low half in Y. A one-cycle done pulse marks the end of either kind of operation.

Top module: `mul_step_unit`

## Requirements
- R1: While rst_ni is low, acc_o, y_o and flags_o read zero and busy_o and done_o are low.
- R2: A step saves Y bit 0 first, then shifts Y right by one. Accumulator bit 0 enters Y bit 31.
- R3: A step shifts the accumulator right by one. The new bit 31 is N XOR V of the incoming flags, where flags bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R4: The shifted accumulator has the multiplicand added when the saved Y bit 0 was 1, and zero added otherwise.
- R5: A step writes the 32-bit sum to the accumulator. It sets N to sum bit 31, Z when the sum is zero, V on signed overflow of the addition, and C on carry out of bit 31.
- R6: With the unit idle, a step_i pulse (and no start_i) takes acc_i, y_i, flags_i and mcand_i. Its result appears on the outputs one cycle later, with done_o high for exactly that cycle.
- R7: With the unit idle, start_i clears the accumulator and the flags, loads Y from y_i and raises busy_o on the next cycle. done_o rises 33 cycles after the start edge, and busy_o falls at the same time.
- R8: The 33rd step of a full run adds zero whatever the Y bit. For a multiplicand and multiplier both below 2^31, {acc_o, y_o} then equals their unsigned 64-bit product.
- R9: While busy_o is high, start_i, step_i and all operand inputs are ignored.
- R10: When start_i and step_i are both high while idle, start_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a full 33-step multiply |
| step_i | input | 1 | Perform one step on port operands |
| mcand_i | input | 32 | Multiplicand |
| acc_i | input | 32 | Accumulator operand for a single step |
| y_i | input | 32 | Y operand for a single step, or the multiplier for start |
| flags_i | input | 4 | Flag operand {N,Z,V,C} for a single step |
| acc_o | output | 32 | Accumulator, or the high product after a full run |
| y_o | output | 32 | Y register, or the low product after a full run |
| flags_o | output | 4 | Flags {N,Z,V,C} |
| busy_o | output | 1 | Full run in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
A single step's result and its done pulse are due one clock edge after the command. The bench therefore drives the command on a falling edge and compares at the next falling edge, then checks one cycle later that done has dropped. For a full run, the bench counts rising edges from the start edge until done is seen, expects 33, and reads the 64-bit product in that same half-cycle, before the next edge could change anything. Commands toggled during a run are removed in the cycle done appears, so any leak from them would show up in the product or in the step count.

// File: rtl/mul_step_pkg.sv
package mul_step_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/mul_step_core.sv
module mul_step_core
  import mul_step_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] y_i,
  input  flags_t           flags_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic             zero_add_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] y_o,
  output flags_t           flags_o
);
  logic             y_lsb;
  logic [WIDTH-1:0] shifted, addend;
  logic [WIDTH:0]   sum;

  always_comb begin
    y_lsb   = y_i[0];
    y_o     = {acc_i[0], y_i[WIDTH-1:1]};
    shifted = {flags_i.n ^ flags_i.v, acc_i[WIDTH-1:1]};
    addend  = (y_lsb && !zero_add_i) ? mcand_i : '0;
    sum     = {1'b0, shifted} + {1'b0, addend};
    acc_o   = sum[WIDTH-1:0];
    flags_o.n = sum[WIDTH-1];
    flags_o.z = (sum[WIDTH-1:0] == '0);
    flags_o.v = (shifted[WIDTH-1] == addend[WIDTH-1]) &&
                (sum[WIDTH-1] != shifted[WIDTH-1]);
    flags_o.c = sum[WIDTH];
  end
endmodule

// File: rtl/mul_step_ctrl.sv
module mul_step_ctrl #(
  parameter int STEPS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_i,
  output logic load_o,
  output logic run_o,
  output logic single_o,
  output logic zero_add_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign load_o     = !busy_q && start_i;
  assign single_o   = !busy_q && !start_i && step_i;
  assign run_o      = busy_q;
  assign zero_add_o = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (single_o) begin
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/mul_step_unit.sv
module mul_step_unit
  import mul_step_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] y_o,
  output logic [3:0]       flags_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [WIDTH-1:0] acc_q, y_q, mc_q;
  flags_t           flg_q;
  logic             load, run, single, zero_add;
  logic [WIDTH-1:0] op_acc, op_y, op_mc, nx_acc, nx_y;
  flags_t           op_flg, nx_flg;

  mul_step_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .step_i,
    .load_o(load), .run_o(run), .single_o(single),
    .zero_add_o(zero_add), .busy_o, .done_o
  );

  // internal state during a run, port operands for a single step
  assign op_acc = run ? acc_q : acc_i;
  assign op_y   = run ? y_q   : y_i;
  assign op_flg = run ? flg_q : flags_t'(flags_i);
  assign op_mc  = run ? mc_q  : mcand_i;

  mul_step_core #(.WIDTH(WIDTH)) u_core (
    .acc_i(op_acc), .y_i(op_y), .flags_i(op_flg), .mcand_i(op_mc),
    .zero_add_i(zero_add),
    .acc_o(nx_acc), .y_o(nx_y), .flags_o(nx_flg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      y_q   <= '0;
      mc_q  <= '0;
      flg_q <= '0;
    end else if (load) begin
      acc_q <= '0;
      y_q   <= y_i;
      mc_q  <= mcand_i;
      flg_q <= '0;
    end else if (run || single) begin
      acc_q <= nx_acc;
      y_q   <= nx_y;
      flg_q <= nx_flg;
    end
  end

  assign acc_o   = acc_q;
  assign y_o     = y_q;
  assign flags_o = flg_q;
endmodule

// File: rtl/mul_step_chk.sv
module mul_step_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             step_i,
  input logic [WIDTH-1:0] acc_i,
  input logic [WIDTH-1:0] y_i,
  input logic [3:0]       flags_i,
  input logic [WIDTH-1:0] acc_o,
  input logic [WIDTH-1:0] y_o,
  input logic [3:0]       flags_o,
  input logic             busy_o,
  input logic             done_o
);
  always_comb begin
    if (!rst_ni) begin
      // R1
      reset_state_chk: assert (acc_o == '0 && y_o == '0 && flags_o == '0 && !busy_o && !done_o);
    end
  end

  // R2
  step_y_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && step_i && !start_i) |=> (y_o == {$past(acc_i[0]), $past(y_i[WIDTH-1:1])}));

  // R4
  no_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && step_i && !start_i && !y_i[0] && flags_i == 4'b0000)
    |=> (acc_o == {1'b0, $past(acc_i[WIDTH-1:1])}));

  // R5
  result_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[2] == (acc_o == '0) && flags_o[3] == acc_o[WIDTH-1]));

  // R6
  step_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && step_i && !start_i) |=> (done_o && !busy_o));

  // R7
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && acc_o == '0 && flags_o == '0 && y_o == $past(y_i)));

  // R7
  run_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> !done_o);

  // R9
  busy_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o || done_o));
endmodule

bind mul_step_unit mul_step_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i, .rst_ni, .start_i, .step_i, .acc_i, .y_i, .flags_i,
  .acc_o, .y_o, .flags_o, .busy_o, .done_o
);

// File: tb/sim_mul_step_unit.sv
module sim_mul_step_unit;
  localparam int  W   = 32;
  localparam time CYC = 10ns;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, step = 1'b0;
  logic [W-1:0]  mcand = '0, acc_in = '0, y_in = '0;
  logic [3:0]    flg_in = '0;
  logic [W-1:0]  acc_o, y_o;
  logic [3:0]    flags_o;
  logic          busy_o, done_o;
  int            n_chk = 0, n_bad = 0;

  always #(CYC/2) clk = ~clk;

  mul_step_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
    .mcand_i(mcand), .acc_i(acc_in), .y_i(y_in), .flags_i(flg_in),
    .acc_o, .y_o, .flags_o, .busy_o, .done_o
  );

  // {multiplicand, multiplier}, both below 2^31
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_0005, 32'h0000_0003},
    {32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {32'h1234_5678, 32'h0ABC_DEF1},
    {32'h0000_0000, 32'h7FFF_FFFF},
    {32'h7FFF_FFFF, 32'h0000_0001},
    {32'h0001_0000, 32'h0001_0000}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference step built from R2..R5: returns {acc, y, N, Z, V, C}
  function automatic logic [67:0] ref_step(input logic [31:0] a, input logic [31:0] y,
                                           input logic [3:0] f, input logic [31:0] m);
    logic [31:0] sh, ad;
    logic [32:0] s;
    logic n, z, v, c;
    sh = {f[3] ^ f[1], a[31:1]};
    ad = y[0] ? m : 32'h0;
    s  = {1'b0, sh} + {1'b0, ad};
    n  = s[31];
    z  = (s[31:0] == 32'h0);
    v  = (sh[31] == ad[31]) && (s[31] != sh[31]);
    c  = s[32];
    return {s[31:0], a[0], y[31:1], n, z, v, c};
  endfunction

  task automatic one_step(input string req, input logic [31:0] a, input logic [31:0] y,
                          input logic [3:0] f, input logic [31:0] m);
    logic [67:0] e;
    e = ref_step(a, y, f, m);
    @(negedge clk);
    acc_in = a; y_in = y; flg_in = f; mcand = m; step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step = 1'b0;
    check(req, {acc_o, y_o, flags_o}, e);
    check("R6 done with result", done_o, 1'b1);
    @(negedge clk);
    check("R6 done one cycle", done_o, 1'b0);
  endtask

  task automatic full_run(input logic [31:0] m, input logic [31:0] mult, input bit noise);
    int n;
    @(negedge clk);
    mcand = m; y_in = mult; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done_o && n < 100) begin
      if (noise) begin
        // R9: toggled commands and operands while busy
        start = ~start; step = 1'b1;
        mcand = ~mcand; y_in = y_in + 32'h1357; acc_in = ~acc_in; flg_in = 4'b1010;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    start = 1'b0; step = 1'b0;
    check("R7 cycles to done", 128'(n), 128'(33));
    check("R8 product", {acc_o, y_o}, 128'(64'(m) * 64'(mult)));
    check("R7 busy falls with done", busy_o, 1'b0);
  endtask

  initial begin
    #(CYC * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    acc_in = '1; y_in = '1; flg_in = '1; mcand = '1; step = 1'b1; start = 1'b1;
    #(CYC * 3 + 1);
    // R1 reset state with active inputs
    check("R1 reset", {acc_o, y_o, flags_o, busy_o, done_o}, '0);
    step = 1'b0; start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R8 table walk
    for (int i = 0; i < 8; i++) full_run(VEC[i][63:32], VEC[i][31:0], 1'b0);

    // R2 R3 R4 R5 directed single steps
    one_step("R4 add taken", 32'h0000_0004, 32'h0000_0003, 4'b0000, 32'h0000_0010);
    one_step("R4 add skipped", 32'h0000_0005, 32'h8000_0002, 4'b0000, 32'hFFFF_FFFF);
    one_step("R3 N xor V feeds top", 32'h0000_0000, 32'h0000_0001, 4'b1000, 32'h8000_0000);
    one_step("R3 N and V cancel", 32'hFFFF_FFFE, 32'h0000_0001, 4'b1010, 32'h0000_0001);
    one_step("R5 overflow", 32'hFFFF_FFFE, 32'h0000_0001, 4'b0000, 32'h0000_0001);
    one_step("R2 acc bit0 into Y", 32'h0000_0001, 32'hAAAA_AAAA, 4'b0010, 32'h1);

    // R5 explicit zero/carry case
    @(negedge clk);
    acc_in = '0; y_in = 32'h1; flg_in = 4'b1000; mcand = 32'h8000_0000; step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step = 1'b0;
    check("R5 Z,V,C set", flags_o, 4'b0111);

    // R9 noise while busy
    full_run(32'h0765_4321, 32'h0012_3457, 1'b1);

    // R10 start over step
    @(negedge clk);
    mcand = 32'd7; y_in = 32'd9; acc_in = 32'hFFFF; flg_in = 4'b1111;
    start = 1'b1; step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    check("R10 start wins", {busy_o, acc_o, y_o, flags_o}, {1'b1, 32'h0, 32'd9, 4'h0});
    for (int k = 0; k < 40 && !done_o; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R10 product", {acc_o, y_o}, 128'(64'd63));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule